// File: doc/BRIEF.md
# Load Queue Snoop Invalidation Checker

This block sits beside the load queue of an out-of-order core. When the coherence fabric reports that a cache line has been invalidated, it compares the line against every in-flight load. A load whose data may now be stale is marked for replay or squash. If the oldest load holds a load-linked reservation on that line, the block reports that the reservation is lost. A load that crosses a cache-line boundary is issued as two requests, and each entry keeps the physical address of both halves. An invalidation of the second half's line is therefore caught as well as one of the first half's line.

Entries are held in a circular buffer. Allocation takes the tail slot, and retirement frees the head slot. Translation later fills in the physical addresses of an entry through an update port that carries an index. A snoop is evaluated against the queue contents present in the cycle of its strobe. The per-entry squash mask and the reservation-lost pulse are registered and appear one cycle later, together with a done pulse. A force input marks every entry that has a translated address, regardless of address. A total-store-order input widens each hit to that load plus every younger allocated load.

Top module: `lsq_snoop_checker`

## Requirements
- R1: After reset the queue reports empty and not full, and squashMask, lockLost and snoopDone are all 0.
- R2: An allocate request writes the slot shown on allocIdx and advances it by one, wrapping from NUM_ENTRIES-1 to 0. An allocate request while queueFull is 1 is ignored and does not advance allocIdx. A retire request frees the oldest slot. A newly allocated slot has no valid address and stored addresses of zero.
- R3: Addresses are compared at line granularity: the low LINE_OFF bits of the snoop address and of the stored addresses are ignored, so any byte address within a load's line hits.
- R4: A non-split entry is compared on its low address only. Its high address never causes a hit, so a snoop of line 0 misses a non-split entry at a non-zero line.
- R5: A split entry hits when the snooped line equals the line of either its low half or its high half.
- R6: Without force, an entry hits only if it is allocated and its address has been translated. Free slots and untranslated entries never appear in squashMask.
- R7: squashMask and lockLost are valid only in the single cycle after a snoop strobe, flagged by snoopDone = 1. In all other cycles they are 0.
- R8: With forceSquash = 1 on a snoop, every allocated entry with a translated address is marked, whether or not its line matches.
- R9: With tsoMode = 1 on a snoop, the oldest marked entry and every allocated entry younger than it in circular order from the head are marked.
- R10: lockLost = 1 only when the oldest entry has a translated address, was allocated with the load-linked flag, and hits the snooped line. Load-linked entries that are not the oldest never raise it.
- R11: An address update aimed at a slot that is not allocated is ignored.
- R12: A snoop whose strobe falls in the same cycle as a retire is judged against the queue as it was before that retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocReq | input | 1 | Allocate the tail slot |
| allocLlsc | input | 1 | The allocated load is load-linked |
| retireReq | input | 1 | Retire the head slot |
| xlatValid | input | 1 | Address update strobe |
| xlatIdx | input | IDX_W | Slot to update |
| xlatSplit | input | 1 | The access was split across two lines |
| xlatAddrLo | input | ADDR_W | Physical address of the single or first request |
| xlatAddrHi | input | ADDR_W | Physical address of the second request |
| snoopValid | input | 1 | Invalidation snoop strobe |
| snoopAddr | input | ADDR_W | Invalidated address |
| forceSquash | input | 1 | Mark all translated entries on this snoop |
| tsoMode | input | 1 | Mark hits plus all younger loads |
| allocIdx | output | IDX_W | Slot the next allocate will take |
| queueFull | output | 1 | All slots allocated |
| queueEmpty | output | 1 | No slot allocated |
| squashMask | output | NUM_ENTRIES | Per-slot squash marks, one cycle after the snoop |
| lockLost | output | 1 | Oldest load lost its reservation |
| snoopDone | output | 1 | Result cycle marker |

## Verification
The case where two functions fall in the same cycle is a snoop strobe together with retirement of the head. The bench raises snoopValid and retireReq on the same cycle, with the snooped line matching the retiring load-linked head. It expects that head's bit in squashMask and a lockLost pulse, because the snoop sees the queue as it was before the retire. A second snoop of the same line right after must then return an empty mask and no reservation loss. This shows that the retire took effect and that the new head is the next entry.

// File: rtl/lsq_snoop_pkg.sv
package lsq_snoop_pkg;

  // Strobes from the queue control to the entry datapath.
  typedef struct packed {
    logic allocEn;   // allocate at the tail this cycle
    logic retireEn;  // free the head this cycle
  } lsqStrobes_t;

endpackage

// File: rtl/lsq_snoop_ctrl.sv
module lsq_snoop_ctrl
  import lsq_snoop_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           allocReq,
  input  logic                           retireReq,
  output lsqStrobes_t                    strobes,
  output logic [$clog2(NUM_ENTRIES)-1:0] headIdx,
  output logic [$clog2(NUM_ENTRIES)-1:0] tailIdx,
  output logic                           queueFull,
  output logic                           queueEmpty
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [CNT_W-1:0] countQ;
  logic [IDX_W-1:0] headQ, tailQ;

  function automatic logic [IDX_W-1:0] wrapInc(input logic [IDX_W-1:0] idx);
    return (idx == LAST_IDX) ? '0 : idx + IDX_W'(1);
  endfunction

  assign queueFull  = (countQ == CNT_W'(NUM_ENTRIES));
  assign queueEmpty = (countQ == '0);

  always_comb begin
    strobes          = '0;
    strobes.allocEn  = allocReq  && !queueFull;
    strobes.retireEn = retireReq && !queueEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      headQ  <= '0;
      tailQ  <= '0;
    end else begin
      if (strobes.allocEn)  tailQ <= wrapInc(tailQ);
      if (strobes.retireEn) headQ <= wrapInc(headQ);
      case ({strobes.allocEn, strobes.retireEn})
        2'b10:   countQ <= countQ + CNT_W'(1);
        2'b01:   countQ <= countQ - CNT_W'(1);
        default: countQ <= countQ;
      endcase
    end
  end

  assign headIdx = headQ;
  assign tailIdx = tailQ;

  // R2: occupancy never exceeds the queue depth
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(NUM_ENTRIES));

  // R2: a retire moves the head one slot on, wrapping at the end
  p_head_advance_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.retireEn |=> headQ == (($past(headQ) == LAST_IDX) ? '0 : $past(headQ) + IDX_W'(1)));

  // R2: a full queue never accepts an allocation
  p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (queueFull && !strobes.retireEn) |=> $stable(tailQ));

endmodule

// File: rtl/lsq_snoop_datapath.sv
module lsq_snoop_datapath
  import lsq_snoop_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  parameter int LINE_OFF    = 6
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  lsqStrobes_t                    strobes,
  input  logic [$clog2(NUM_ENTRIES)-1:0] headIdx,
  input  logic [$clog2(NUM_ENTRIES)-1:0] tailIdx,
  input  logic                           allocLlsc,
  input  logic                           xlatValid,
  input  logic [$clog2(NUM_ENTRIES)-1:0] xlatIdx,
  input  logic                           xlatSplit,
  input  logic [ADDR_W-1:0]              xlatAddrLo,
  input  logic [ADDR_W-1:0]              xlatAddrHi,
  input  logic                           snoopValid,
  input  logic [ADDR_W-1:0]              snoopAddr,
  input  logic                           forceSquash,
  input  logic                           tsoMode,
  output logic [NUM_ENTRIES-1:0]         squashMask,
  output logic                           lockLost,
  output logic                           snoopDone
);
  localparam int IDX_W  = $clog2(NUM_ENTRIES);
  localparam int AGE_W  = IDX_W + 1;
  localparam int LINE_W = ADDR_W - LINE_OFF;

  logic [NUM_ENTRIES-1:0] allocQ, addrOkQ, splitQ, llscQ;
  logic [ADDR_W-1:0]      addrLoQ [NUM_ENTRIES];
  logic [ADDR_W-1:0]      addrHiQ [NUM_ENTRIES];

  logic [LINE_W-1:0]      snoopLine;
  logic [NUM_ENTRIES-1:0] hitVec, trigVec, squashNext;
  logic [AGE_W-1:0]       ageVec [NUM_ENTRIES];
  logic [AGE_W-1:0]       oldestTrigAge;
  logic                   anyTrig;
  logic                   lockNext;

  logic [NUM_ENTRIES-1:0] squashQ;
  logic                   lockQ, doneQ;

  assign snoopLine = snoopAddr[ADDR_W-1:LINE_OFF];

  // Per-entry storage and comparison
  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_entry
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(gi);
    logic isAlloc, isRetire, isXlat;

    assign isAlloc  = strobes.allocEn  && (tailIdx == MY_IDX);
    assign isRetire = strobes.retireEn && (headIdx == MY_IDX);
    assign isXlat   = xlatValid && (xlatIdx == MY_IDX) && allocQ[gi];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        allocQ[gi]  <= 1'b0;
        addrOkQ[gi] <= 1'b0;
        splitQ[gi]  <= 1'b0;
        llscQ[gi]   <= 1'b0;
        addrLoQ[gi] <= '0;
        addrHiQ[gi] <= '0;
      end else if (isAlloc) begin
        allocQ[gi]  <= 1'b1;
        addrOkQ[gi] <= 1'b0;
        splitQ[gi]  <= 1'b0;
        llscQ[gi]   <= allocLlsc;
        addrLoQ[gi] <= '0;
        addrHiQ[gi] <= '0;
      end else begin
        if (isXlat) begin
          addrOkQ[gi] <= 1'b1;
          splitQ[gi]  <= xlatSplit;
          addrLoQ[gi] <= xlatAddrLo;
          addrHiQ[gi] <= xlatSplit ? xlatAddrHi : '0;
        end
        if (isRetire) begin
          allocQ[gi]  <= 1'b0;
          addrOkQ[gi] <= 1'b0;
        end
      end
    end

    logic loMatch, hiMatch;
    assign loMatch = (addrLoQ[gi][ADDR_W-1:LINE_OFF] == snoopLine);
    assign hiMatch = splitQ[gi] && (addrHiQ[gi][ADDR_W-1:LINE_OFF] == snoopLine);
    assign hitVec[gi]  = allocQ[gi] && addrOkQ[gi] && (loMatch || hiMatch);
    assign trigVec[gi] = hitVec[gi] || (forceSquash && allocQ[gi] && addrOkQ[gi]);

    // Distance from the head in circular order; 0 is the oldest slot
    assign ageVec[gi] = (MY_IDX >= headIdx)
                        ? AGE_W'(MY_IDX) - AGE_W'(headIdx)
                        : AGE_W'(MY_IDX) + AGE_W'(NUM_ENTRIES) - AGE_W'(headIdx);
  end

  // Age of the oldest marked entry, used for the ordered widening
  always_comb begin
    anyTrig       = 1'b0;
    oldestTrigAge = AGE_W'(NUM_ENTRIES);
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (trigVec[i] && (ageVec[i] < oldestTrigAge)) begin
        oldestTrigAge = ageVec[i];
        anyTrig       = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (tsoMode) squashNext[i] = allocQ[i] && anyTrig && (ageVec[i] >= oldestTrigAge);
      else         squashNext[i] = trigVec[i];
    end
  end

  assign lockNext = hitVec[headIdx] && llscQ[headIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      squashQ <= '0;
      lockQ   <= 1'b0;
      doneQ   <= 1'b0;
    end else if (snoopValid) begin
      squashQ <= squashNext;
      lockQ   <= lockNext;
      doneQ   <= 1'b1;
    end else begin
      squashQ <= '0;
      lockQ   <= 1'b0;
      doneQ   <= 1'b0;
    end
  end

  assign squashMask = squashQ;
  assign lockLost   = lockQ;
  assign snoopDone  = doneQ;

  // R6: only slots allocated at snoop time can be marked
  p_alloc_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    snoopDone |-> ((squashMask & ~$past(allocQ)) == '0));

  // R7: results are quiet outside the result cycle
  p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !snoopDone |-> (squashMask == '0 && !lockLost));

  // R10: a lost reservation always comes with the head being marked
  p_lock_marks_head_r10: assert property (@(posedge clk) disable iff (!rstN)
    lockLost |-> squashMask[$past(headIdx)]);

  // R2: a fresh allocation starts with no translated address
  p_alloc_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.allocEn |=> !addrOkQ[$past(tailIdx)]);

endmodule

// File: rtl/lsq_snoop_checker.sv
module lsq_snoop_checker
  import lsq_snoop_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  parameter int LINE_OFF    = 6,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   allocReq,
  input  logic                   allocLlsc,
  input  logic                   retireReq,
  input  logic                   xlatValid,
  input  logic [IDX_W-1:0]       xlatIdx,
  input  logic                   xlatSplit,
  input  logic [ADDR_W-1:0]      xlatAddrLo,
  input  logic [ADDR_W-1:0]      xlatAddrHi,
  input  logic                   snoopValid,
  input  logic [ADDR_W-1:0]      snoopAddr,
  input  logic                   forceSquash,
  input  logic                   tsoMode,
  output logic [IDX_W-1:0]       allocIdx,
  output logic                   queueFull,
  output logic                   queueEmpty,
  output logic [NUM_ENTRIES-1:0] squashMask,
  output logic                   lockLost,
  output logic                   snoopDone
);
  lsqStrobes_t      strobes;
  logic [IDX_W-1:0] headIdx, tailIdx;

  lsq_snoop_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .retireReq(retireReq),
    .strobes(strobes), .headIdx(headIdx), .tailIdx(tailIdx),
    .queueFull(queueFull), .queueEmpty(queueEmpty)
  );

  lsq_snoop_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .headIdx(headIdx), .tailIdx(tailIdx),
    .allocLlsc(allocLlsc), .xlatValid(xlatValid), .xlatIdx(xlatIdx), .xlatSplit(xlatSplit),
    .xlatAddrLo(xlatAddrLo), .xlatAddrHi(xlatAddrHi), .snoopValid(snoopValid),
    .snoopAddr(snoopAddr), .forceSquash(forceSquash), .tsoMode(tsoMode),
    .squashMask(squashMask), .lockLost(lockLost), .snoopDone(snoopDone)
  );

  assign allocIdx = tailIdx;

endmodule

// File: tb/test_lsq_snoop_checker.sv
module test_lsq_snoop_checker;
  localparam int N = 8;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocReq = 0, allocLlsc = 0, retireReq = 0;
  logic xlatValid = 0, xlatSplit = 0;
  logic [2:0] xlatIdx = '0;
  logic [AW-1:0] xlatAddrLo = '0, xlatAddrHi = '0, snoopAddr = '0;
  logic snoopValid = 0, forceSquash = 0, tsoMode = 0;
  logic [2:0] allocIdx;
  logic queueFull, queueEmpty, lockLost, snoopDone;
  logic [N-1:0] squashMask;

  always #2 clk = ~clk;

  lsq_snoop_checker i_lsq_snoop_checker (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .allocLlsc(allocLlsc), .retireReq(retireReq),
    .xlatValid(xlatValid), .xlatIdx(xlatIdx), .xlatSplit(xlatSplit), .xlatAddrLo(xlatAddrLo),
    .xlatAddrHi(xlatAddrHi), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .forceSquash(forceSquash), .tsoMode(tsoMode), .allocIdx(allocIdx), .queueFull(queueFull),
    .queueEmpty(queueEmpty), .squashMask(squashMask), .lockLost(lockLost), .snoopDone(snoopDone)
  );

  typedef struct {
    logic [N-1:0] mask;
    logic         lock;
    string        req;
  } expItem_t;

  expItem_t sbQ[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares each result cycle against the scoreboard head
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (snoopDone) begin
        if (sbQ.size() == 0) begin
          chk(1'b0, "R7", "unexpected result", 32'(squashMask), 32'h0);
        end else begin
          expItem_t e;
          e = sbQ.pop_front();
          chk(squashMask == e.mask, e.req, "squashMask", 32'(squashMask), 32'(e.mask));
          chk(lockLost == e.lock, e.req, "lockLost", 32'(lockLost), 32'(e.lock));
        end
      end else begin
        chk(squashMask == '0 && !lockLost, "R7", "idle outputs",
            {23'h0, lockLost, squashMask}, 32'h0);
      end
    end
  end

  task automatic doAlloc(input logic llsc);
    allocReq = 1; allocLlsc = llsc;
    @(negedge clk);
    allocReq = 0; allocLlsc = 0;
  endtask

  task automatic doXlat(input int idx, input logic split, input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    xlatValid = 1; xlatIdx = 3'(idx); xlatSplit = split; xlatAddrLo = lo; xlatAddrHi = hi;
    @(negedge clk);
    xlatValid = 0; xlatSplit = 0;
  endtask

  task automatic doSnoop(input logic [AW-1:0] a, input logic frc, input logic tso, input logic ret,
                         input logic [N-1:0] expMask, input logic expLock, input string req);
    expItem_t e;
    e.mask = expMask; e.lock = expLock; e.req = req;
    sbQ.push_back(e);
    snoopValid = 1; snoopAddr = a; forceSquash = frc; tsoMode = tso; retireReq = ret;
    @(negedge clk);
    snoopValid = 0; forceSquash = 0; tsoMode = 0; retireReq = 0;
    @(negedge clk);
  endtask

  task automatic doRetire();
    retireReq = 1;
    @(negedge clk);
    retireReq = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(queueEmpty == 1 && queueFull == 0, "R1", "empty/full", {30'h0, queueEmpty, queueFull}, 32'h2);
    chk(squashMask == '0 && !lockLost && !snoopDone, "R1", "outputs",
        {22'h0, snoopDone, lockLost, squashMask}, 32'h0);
    chk(allocIdx == 3'd0, "R2", "first slot", 32'(allocIdx), 32'h0);

    // Fill all eight slots; slots 0 and 3 are load-linked
    for (int i = 0; i < N; i++) doAlloc((i == 0) || (i == 3));
    chk(queueFull == 1, "R2", "full after eight", 32'(queueFull), 32'h1);
    doAlloc(1'b1); // ignored while full
    chk(queueFull == 1 && allocIdx == 3'd0, "R2", "alloc while full", 32'(allocIdx), 32'h0);

    doXlat(0, 0, 32'h1000_0040, 32'h0);
    doXlat(1, 1, 32'h2000_0FF8, 32'h2000_1000);
    doXlat(2, 0, 32'h3000_0000, 32'h0);
    doXlat(3, 0, 32'h2000_1010, 32'h0);
    doXlat(5, 0, 32'h0000_0080, 32'h0);
    doXlat(6, 1, 32'h4000_0038, 32'h4000_0040);
    doXlat(7, 0, 32'h5000_0000, 32'h0);

    doSnoop(32'h1000_007F, 0, 0, 0, 8'h01, 1'b1, "R3/R10");
    doSnoop(32'h2000_1000, 0, 0, 0, 8'h0A, 1'b0, "R5/R10");
    doSnoop(32'h2000_0FC0, 0, 0, 0, 8'h02, 1'b0, "R5");
    doSnoop(32'h0000_0000, 0, 0, 0, 8'h00, 1'b0, "R4/R6");
    doSnoop(32'h3000_0000, 0, 0, 0, 8'h04, 1'b0, "R4");
    doSnoop(32'h7000_0000, 1, 0, 0, 8'hEF, 1'b0, "R8");
    doSnoop(32'h3000_0000, 0, 1, 0, 8'hFC, 1'b0, "R9");
    doSnoop(32'h4000_0040, 0, 1, 0, 8'hC0, 1'b0, "R9/R5");

    // Snoop and retire of the load-linked head in the same cycle
    doSnoop(32'h1000_0040, 0, 0, 1, 8'h01, 1'b1, "R12");
    doSnoop(32'h1000_0040, 0, 0, 0, 8'h00, 1'b0, "R12");
    doSnoop(32'h2000_1000, 0, 0, 0, 8'h0A, 1'b0, "R10");
    doRetire();
    doRetire();
    doSnoop(32'h2000_1000, 0, 0, 0, 8'h08, 1'b1, "R10");

    // Update aimed at a free slot is ignored
    doXlat(0, 0, 32'h6000_0000, 32'h0);
    doSnoop(32'h6000_0000, 0, 0, 0, 8'h00, 1'b0, "R11");

    chk(allocIdx == 3'd0, "R2", "wrap slot", 32'(allocIdx), 32'h0);
    doAlloc(1'b0);
    doSnoop(32'h0000_0000, 1, 0, 0, 8'hE8, 1'b0, "R6/R8");
    doXlat(0, 0, 32'h6000_0000, 32'h0);
    doSnoop(32'h5000_0000, 0, 1, 0, 8'h81, 1'b0, "R9");
    doSnoop(32'h6000_0000, 0, 0, 0, 8'h01, 1'b0, "R11");

    repeat (2) @(negedge clk);
    chk(sbQ.size() == 0, "R7", "pending results", 32'(sbQ.size()), 32'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule